// File: doc/BRIEF.md
# Banked GPIO Interrupt Status and Mask Unit

This block gathers single-cycle event pulses from up to eight banks of GPIO pins and turns them into one interrupt line per bank. Each bank keeps a sticky pending register, in which an event pulse sets its bit, and a mask register, in which a set bit blocks that pin from the bank's interrupt line. Edge detection and debounce happen upstream; this block only consumes their pulses.

Software reaches the registers through a simple synchronous port with separate read and write strobes and a byte address. Pending bits are cleared by writing ones to the status register. The mask is never written directly: one register sets mask bits for each one written, and another clears mask bits for each one written. Zeros written to any of these registers change nothing. A pending bit keeps latching while masked, so unmasking a pin that already saw an event raises the line at once.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every mask bit is 1, every status bit is 0 and every interrupt line is low.
- R2: An event pulse on a pin sets that pin's status bit on the next clock edge, whether or not the pin is masked, and the bit stays set until cleared. A bit cleared in one cycle latches again on a later event.
- R3: A write to the status register of bank b (byte address 0x080 + 4*b) clears each status bit written as 1; bits written as 0 keep their value.
- R4: When an event and a clearing write hit the same status bit on the same clock edge, the bit is set after that edge.
- R5: A write to the mask-set register of bank b (byte address 0x0A0 + 4*b) sets each mask bit written as 1 and leaves the others unchanged.
- R6: A write to the mask-clear register of bank b (byte address 0x0C0 + 4*b) clears each mask bit written as 1 and leaves the others unchanged.
- R7: Interrupt line b is high after a clock edge exactly when some bit of bank b is set in status and clear in mask after that edge.
- R8: A read returns data on the clock edge after the read strobe: the status register address returns the status bits, both mask addresses return the current mask, and any other address (including banks beyond the configured count) returns 0. Writes to such other addresses change no state.
- R9: A write or an event aimed at one bank leaves the status and mask of every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NUM_BANKS*PINS | Event pulses, bank b pin p at bit b*PINS+p |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | PINS | Write data |
| reg_rdata | output | PINS | Read data, valid the cycle after reg_rd |
| irq_o | output | NUM_BANKS | Per-bank interrupt line |

## Verification
A corrupted pending or mask bit shows up in two places: the bank's interrupt line, which follows the stored bits on the same edge that changes them, and a register read one cycle later. The directed tests therefore pair every stimulus with a readback of both registers and a look at the line, so a wrong bit is seen within two cycles of the access that exposed it. Collisions of events with clears, zero-bit writes, and accesses to the wrong bank or an unmapped address are each checked at the ports.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int MAX_BANKS = 8;
  localparam int STAT_OFS  = 'h080;
  localparam int MSET_OFS  = 'h0A0;
  localparam int MCLR_OFS  = 'h0C0;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_STAT = 2'd1,
    RK_MSET = 2'd2,
    RK_MCLR = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [2:0]        bank
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] MSET_A = ADDR_W'(MSET_OFS);
  localparam logic [ADDR_W-1:0] MCLR_A = ADDR_W'(MCLR_OFS);

  logic bank_ok;

  always_comb begin
    bank    = addr[4:2];
    bank_ok = (32'(addr[4:2]) < NUM_BANKS);
    kind    = RK_NONE;
    if (bank_ok) begin
      if (addr[ADDR_W-1:5] == STAT_A[ADDR_W-1:5])      kind = RK_STAT;
      else if (addr[ADDR_W-1:5] == MSET_A[ADDR_W-1:5]) kind = RK_MSET;
      else if (addr[ADDR_W-1:5] == MCLR_A[ADDR_W-1:5]) kind = RK_MCLR;
    end
  end
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int PINS = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] evt_i,
  input  logic [PINS-1:0] stat_clr_i,
  input  logic [PINS-1:0] mask_set_i,
  input  logic [PINS-1:0] mask_clr_i,
  output logic [PINS-1:0] status_o,
  output logic [PINS-1:0] mask_o,
  output logic            irq_o
);
  logic [PINS-1:0] status_q, status_d;
  logic [PINS-1:0] mask_q, mask_d;
  logic            irq_q;

  // Event outranks a clear on the same bit; set outranks clear on the mask.
  always_comb begin
    status_d = (status_q & ~stat_clr_i) | evt_i;
    mask_d   = (mask_q & ~mask_clr_i) | mask_set_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '1;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
      irq_q    <= |(status_d & ~mask_d);
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = irq_q;

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == '1 && status_q == '0 && !irq_q));

  a_r2_event_latches: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

  a_r3_sticky_unless_cleared: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & $past(status_q & ~stat_clr_i)) == $past(status_q & ~stat_clr_i)));

  a_r5_mask_set: assert property (@(posedge clk) disable iff (rst)
    (mask_set_i != '0) |=> ((mask_q & $past(mask_set_i)) == $past(mask_set_i)));

  a_r6_mask_clear: assert property (@(posedge clk) disable iff (rst)
    (mask_clr_i != '0 && mask_set_i == '0) |=> ((mask_q & $past(mask_clr_i)) == '0));

  a_r7_line_matches_state: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(status_q & ~mask_q));
endmodule

// File: rtl/irq_readback.sv
module irq_readback
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int PINS      = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rd,
  input  reg_kind_e                 kind,
  input  logic [2:0]                bank,
  input  logic [NUM_BANKS*PINS-1:0] status_all,
  input  logic [NUM_BANKS*PINS-1:0] mask_all,
  output logic [PINS-1:0]           rdata
);
  logic [PINS-1:0] sel_d;
  logic [PINS-1:0] rdata_q;

  always_comb begin
    sel_d = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (32'(bank) == b) begin
        case (kind)
          RK_STAT:          sel_d = status_all[b*PINS +: PINS];
          RK_MSET, RK_MCLR: sel_d = mask_all[b*PINS +: PINS];
          default:          sel_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= sel_d;
  end

  assign rdata = rdata_q;

  a_r8_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd && kind == RK_NONE) |=> (rdata_q == '0));
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int PINS      = 32,
  parameter int ADDR_W    = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_BANKS*PINS-1:0] evt_i,
  input  logic                      reg_wr,
  input  logic                      reg_rd,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [PINS-1:0]           reg_wdata,
  output logic [PINS-1:0]           reg_rdata,
  output logic [NUM_BANKS-1:0]      irq_o
);
  localparam int TOTAL = NUM_BANKS * PINS;

  reg_kind_e        kind;
  logic [2:0]       bank_sel;
  logic [TOTAL-1:0] status_all;
  logic [TOTAL-1:0] mask_all;

  irq_reg_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
    .addr (reg_addr),
    .kind (kind),
    .bank (bank_sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [2:0] BIDX = 3'(b);
    logic            hit;
    logic [PINS-1:0] stat_clr, mset, mclr;

    always_comb begin
      hit      = reg_wr && (bank_sel == BIDX);
      stat_clr = (hit && kind == RK_STAT) ? reg_wdata : '0;
      mset     = (hit && kind == RK_MSET) ? reg_wdata : '0;
      mclr     = (hit && kind == RK_MCLR) ? reg_wdata : '0;
    end

    irq_bank #(.PINS(PINS)) u_bank (
      .clk        (clk),
      .rst        (rst),
      .evt_i      (evt_i[b*PINS +: PINS]),
      .stat_clr_i (stat_clr),
      .mask_set_i (mset),
      .mask_clr_i (mclr),
      .status_o   (status_all[b*PINS +: PINS]),
      .mask_o     (mask_all[b*PINS +: PINS]),
      .irq_o      (irq_o[b])
    );
  end

  irq_readback #(.NUM_BANKS(NUM_BANKS), .PINS(PINS)) u_rb (
    .clk        (clk),
    .rst        (rst),
    .rd         (reg_rd),
    .kind       (kind),
    .bank       (bank_sel),
    .status_all (status_all),
    .mask_all   (mask_all),
    .rdata      (reg_rdata)
  );

  initial begin
    a_r9_bank_limit: assert (NUM_BANKS >= 1 && NUM_BANKS <= MAX_BANKS);
  end
endmodule

// File: tb/gpio_irq_unit_tb.sv
module gpio_irq_unit_tb;
  localparam int NB = 2;
  localparam int P  = 32;
  localparam int AW = 12;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NB*P-1:0] evt = '0;
  logic            wr = 1'b0, rd = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [P-1:0]    wdata = '0;
  logic [P-1:0]    rdata;
  logic [NB-1:0]   irq;

  int checks = 0;
  int errors = 0;

  gpio_irq_unit #(.NUM_BANKS(NB), .PINS(P), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .evt_i(evt), .reg_wr(wr), .reg_rd(rd),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
  );

  always #5 clk = ~clk;

  function automatic logic [AW-1:0] a_stat(int b); return AW'('h080 + 4*b); endfunction
  function automatic logic [AW-1:0] a_mset(int b); return AW'('h0A0 + 4*b); endfunction
  function automatic logic [AW-1:0] a_mclr(int b); return AW'('h0C0 + 4*b); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [AW-1:0] a, logic [P-1:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(logic [AW-1:0] a, output logic [P-1:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(logic [NB*P-1:0] v);
    @(negedge clk);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic t_reset();
    logic [P-1:0] d;
    rd_reg(a_stat(0), d); chk("R1 status b0", d, 32'h0);
    rd_reg(a_mset(0), d); chk("R1 mask b0", d, 32'hFFFF_FFFF);
    rd_reg(a_mset(1), d); chk("R1 mask b1", d, 32'hFFFF_FFFF);
    chk("R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_latch_and_unmask();
    logic [P-1:0] d;
    pulse(64'h8);
    rd_reg(a_stat(0), d); chk("R2 latched while masked", d, 32'h8);
    chk("R7 masked no irq", 32'(irq), 32'h0);
    wr_reg(a_mclr(0), 32'h0);
    rd_reg(a_mset(0), d); chk("R6 zero clear no effect", d, 32'hFFFF_FFFF);
    wr_reg(a_mclr(0), 32'h8);
    chk("R7 irq after unmask", 32'(irq), 32'h1);
    rd_reg(a_mclr(0), d); chk("R8 mask read via clear addr", d, 32'hFFFF_FFF7);
  endtask

  task automatic t_w1c();
    logic [P-1:0] d;
    wr_reg(a_stat(0), 32'h0);
    rd_reg(a_stat(0), d); chk("R3 zero write keeps status", d, 32'h8);
    wr_reg(a_stat(0), 32'h8);
    chk("R7 irq drops after clear", 32'(irq), 32'h0);
    rd_reg(a_stat(0), d); chk("R3 status cleared", d, 32'h0);
    pulse(64'h8);
    rd_reg(a_stat(0), d); chk("R2 relatches after clear", d, 32'h8);
  endtask

  task automatic t_collision();
    logic [P-1:0] d;
    @(negedge clk);
    evt = 64'h8; wr = 1'b1; addr = a_stat(0); wdata = 32'h8;
    @(negedge clk);
    evt = '0; wr = 1'b0;
    chk("R4 irq held on collision", 32'(irq), 32'h1);
    rd_reg(a_stat(0), d); chk("R4 event wins over clear", d, 32'h8);
  endtask

  task automatic t_mask_set();
    logic [P-1:0] d;
    wr_reg(a_mset(0), 32'h0);
    chk("R5 zero set keeps irq", 32'(irq), 32'h1);
    wr_reg(a_mset(0), 32'h8);
    chk("R5 irq off after mask set", 32'(irq), 32'h0);
    rd_reg(a_mset(0), d); chk("R5 mask all set", d, 32'hFFFF_FFFF);
    rd_reg(a_stat(0), d); chk("R2 status kept under mask", d, 32'h8);
  endtask

  task automatic t_init_seq();
    logic [P-1:0] d;
    wr_reg(a_mclr(0), 32'h0000_00F0);
    pulse(64'h30);
    wr_reg(a_mset(0), 32'hFFFF_FFFF);
    wr_reg(a_stat(0), 32'hFFFF_FFFF);
    rd_reg(a_stat(0), d); chk("R3 init status clear", d, 32'h0);
    rd_reg(a_mset(0), d); chk("R5 init fully masked", d, 32'hFFFF_FFFF);
    chk("R7 init irq low", 32'(irq), 32'h0);
  endtask

  task automatic t_banks();
    logic [P-1:0] d;
    pulse(64'h8000_0000_0000_0000);
    rd_reg(a_stat(1), d); chk("R9 bank1 status", d, 32'h8000_0000);
    rd_reg(a_stat(0), d); chk("R9 bank0 untouched", d, 32'h0);
    wr_reg(a_mclr(1), 32'h8000_0000);
    chk("R9 only bank1 irq", 32'(irq), 32'h2);
    rd_reg(a_mset(0), d); chk("R9 bank0 mask untouched", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_unmapped();
    logic [P-1:0] d;
    wr_reg(AW'('h088), 32'hFFFF_FFFF);
    wr_reg(AW'('h0E4), 32'hFFFF_FFFF);
    rd_reg(a_stat(1), d); chk("R8 stray write ignored", d, 32'h8000_0000);
    chk("R8 irq unchanged", 32'(irq), 32'h2);
    rd_reg(AW'('h088), d); chk("R8 absent bank reads 0", d, 32'h0);
    rd_reg(AW'('h000), d); chk("R8 unmapped reads 0", d, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_latch_and_unmask();
    t_w1c();
    t_collision();
    t_mask_set();
    t_init_seq();
    t_banks();
    t_unmapped();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule